// File: doc/BRIEF.md
# Packed-Slot Instruction Fetch and Issue Sequencer

This block is the front end of a small stack processor. Program memory holds 18-bit words, and each word packs up to four opcodes. The block fetches one word from memory, then hands its opcodes to the execute stage one per cycle, tagged with the position they came from. Fetching a word takes a cycle of its own, in which nothing is issued. The last position in a word is only three bits wide. Its code is widened to a five-bit opcode whose two low bits are zero, so only one opcode in four can be placed there.

A literal-load opcode does not carry its value in the word. In the cycle that it issues, the block reads the next program word and passes the whole word out as data. The program counter then moves past that word. A control-transfer opcode (return, jump, call or conditional branch) ends the current word at once, and the block fetches sequentially. When the execute stage resolves a transfer as taken, it raises a redirect with the target address. The redirect cancels whatever the block was doing that cycle, and the next fetch comes from the target. A stall freezes the whole sequencer.

Top module: `bsq_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_req` is 1, `fetch_addr` equals `RESET_PC` (0 by default) and `issue_valid` is 0.
- R2: Slot fields, from the most significant bit down, are 17:13 for slot 0, 12:8 for slot 1, 7:3 for slot 2 and 2:0 for slot 3. A slot-3 code c issues as opcode {c, 2'b00}. Slots issue in the order 0, 1, 2, 3, and `issue_slot` carries the index.
- R3: Each issued opcode takes exactly one cycle. A word of four ordinary opcodes therefore takes five cycles: one to fetch and four to issue.
- R4: `fetch_addr` increments by one after each accepted fetch. An accepted fetch is `fetch_req` and `word_valid` high with no redirect in that cycle.
- R5: The literal opcode is 5'h08. In its issue cycle the block raises `fetch_req` at the next address. The opcode issues only when `word_valid` is high, and in that cycle `lit_valid` is 1 and `lit_data` equals the fetched word. That word is never decoded as opcodes.
- R6: Opcodes 5'h00 to 5'h03 are control transfers. After one of them issues, no further slot of that word issues, and the next cycle fetches the following word.
- R7: A redirect when there is no stall suppresses any issue in that cycle. It also discards any word arriving in that cycle, and the next cycle fetches from `redirect_target`.
- R8: While `stall` is 1, `issue_valid`, `fetch_req` and `lit_valid` are 0. The next cycle shows the same `fetch_addr`, `issue_slot` and `issue_op`.
- R9: During a word fetch with `word_valid` low, nothing issues and the fetch address is held until the word arrives.
- R10: A redirect that comes together with a stall has no effect. After the stall, the bundle resumes at the held slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze request from the execute stage |
| redirect_req | input | 1 | Taken control transfer |
| redirect_target | input | PC_W | Address to fetch after a redirect |
| word_in | input | 18 | Word returned by program memory |
| word_valid | input | 1 | `word_in` is valid this cycle |
| fetch_req | output | 1 | Memory read request |
| fetch_addr | output | PC_W | Program counter, the address of the read |
| issue_valid | output | 1 | An opcode issues this cycle |
| issue_op | output | 5 | Opcode being issued |
| issue_slot | output | 2 | Slot index of the opcode being issued |
| lit_valid | output | 1 | Literal data is valid this cycle |
| lit_data | output | 18 | Literal word for the execute stage |

## Verification
A literal load and a redirect can fall in the same cycle. The literal is reading its data word while a redirect from an earlier transfer arrives. The bench provokes this by raising the redirect in the first cycle of a word whose slot 0 is a literal. It judges the outcome by three things: no literal data is presented, the data word is not consumed, and the next opcode issued is slot 0 of the word at the target. A second pairing raises a stall and a redirect together, and the bench confirms that the bundle continues where it stopped.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int WORD_W = 18;
    localparam int OP_W   = 5;
    localparam int NSLOT  = 4;
    localparam int LAST_W = 3;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int PAD_W  = OP_W - LAST_W;

    typedef logic [OP_W-1:0]   opcode_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    localparam opcode_t OP_RET  = 5'h00;
    localparam opcode_t OP_JUMP = 5'h01;
    localparam opcode_t OP_CALL = 5'h02;
    localparam opcode_t OP_BRZ  = 5'h03;
    localparam opcode_t OP_LIT  = 5'h08;
    localparam opcode_t OP_NOP  = 5'h1C;

    typedef struct packed {
        opcode_t op;
        logic    ctrl;
        logic    lit;
    } slot_info_t;

    // Control transfers occupy the lowest group of codes
    function automatic logic is_ctrl(opcode_t op);
        return op[OP_W-1:PAD_W] == '0;
    endfunction

    function automatic logic is_lit(opcode_t op);
        return op == OP_LIT;
    endfunction

    // Short last slot: code sits in the high bits, low bits are zero
    function automatic opcode_t widen_last(logic [LAST_W-1:0] code);
        return {code, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/bsq_slot_unpack.sv
module bsq_slot_unpack
    import bsq_pkg::*;
(
    input  word_t                  word,
    output opcode_t [NSLOT-1:0]    slot_ops
);
    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            if (i < NSLOT - 1) begin : g_full
                localparam int HI = WORD_W - 1 - i * OP_W;
                assign slot_ops[i] = word[HI -: OP_W];
            end else begin : g_short
                assign slot_ops[i] = widen_last(word[LAST_W-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/bsq_slot_select.sv
module bsq_slot_select
    import bsq_pkg::*;
(
    input  opcode_t [NSLOT-1:0] slot_ops,
    input  slot_idx_t           slot_idx,
    output slot_info_t          info
);
    opcode_t sel_op;

    always_comb begin
        sel_op    = slot_ops[slot_idx];
        info.op   = sel_op;
        info.ctrl = is_ctrl(sel_op);
        info.lit  = is_lit(sel_op);
    end
endmodule

// File: rtl/bsq_pc_unit.sv
module bsq_pc_unit #(
    parameter int              PC_W     = 10,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    input  logic            inc,
    output logic [PC_W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_PC;
        end else if (load) begin
            pc <= load_val;
        end else if (inc) begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/bsq_sequencer.sv
module bsq_sequencer
    import bsq_pkg::*;
#(
    parameter int              PC_W     = 10,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              redirect_req,
    input  logic [PC_W-1:0]   redirect_target,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic              fetch_req,
    output logic [PC_W-1:0]   fetch_addr,
    output logic              issue_valid,
    output logic [OP_W-1:0]   issue_op,
    output logic [SLOT_W-1:0] issue_slot,
    output logic              lit_valid,
    output logic [WORD_W-1:0] lit_data
);
    localparam slot_idx_t LAST_SLOT = slot_idx_t'(NSLOT - 1);

    seq_state_e          state_q;
    slot_idx_t           slot_q;
    word_t               word_q;
    opcode_t [NSLOT-1:0] slot_ops;
    slot_info_t          cur;
    logic [PC_W-1:0]     pc;

    logic in_issue;
    logic take_redirect;
    logic lit_fetch;
    logic word_take;
    logic issue_fire;
    logic bundle_end;

    bsq_slot_unpack u_unpack (
        .word     (word_q),
        .slot_ops (slot_ops)
    );

    bsq_slot_select u_select (
        .slot_ops (slot_ops),
        .slot_idx (slot_q),
        .info     (cur)
    );

    bsq_pc_unit #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (take_redirect),
        .load_val (redirect_target),
        .inc      (word_take),
        .pc       (pc)
    );

    always_comb begin
        in_issue      = (state_q == ST_ISSUE);
        take_redirect = redirect_req && !stall;
        lit_fetch     = in_issue && cur.lit;
        fetch_req     = !stall && ((state_q == ST_FETCH) || lit_fetch);
        word_take     = fetch_req && word_valid && !redirect_req;
        issue_fire    = in_issue && !stall && !redirect_req
                        && (!cur.lit || word_valid);
        bundle_end    = cur.ctrl || (slot_q == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            slot_q  <= '0;
            word_q  <= '0;
        end else if (!stall) begin
            if (redirect_req) begin
                state_q <= ST_FETCH;
                slot_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_FETCH: begin
                        if (word_valid) begin
                            word_q  <= word_in;
                            slot_q  <= '0;
                            state_q <= ST_ISSUE;
                        end
                    end
                    ST_ISSUE: begin
                        if (issue_fire) begin
                            if (bundle_end) begin
                                state_q <= ST_FETCH;
                                slot_q  <= '0;
                            end else begin
                                slot_q <= slot_q + 1'b1;
                            end
                        end
                    end
                    default: state_q <= ST_FETCH;
                endcase
            end
        end
    end

    assign fetch_addr  = pc;
    assign issue_valid = issue_fire;
    assign issue_op    = cur.op;
    assign issue_slot  = slot_q;
    assign lit_valid   = issue_fire && cur.lit;
    assign lit_data    = word_in;
endmodule

// File: rtl/bsq_sequencer_chk.sv
module bsq_sequencer_chk
    import bsq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              redirect_req,
    input logic [PC_W-1:0]   redirect_target,
    input logic              word_valid,
    input logic              fetch_req,
    input logic [PC_W-1:0]   fetch_addr,
    input logic              issue_valid,
    input logic [OP_W-1:0]   issue_op,
    input logic [SLOT_W-1:0] issue_slot,
    input logic              lit_valid
);
    assert_short_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_slot == SLOT_W'(NSLOT - 1)) |-> (issue_op[PAD_W-1:0] == '0));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && word_valid && !redirect_req)
        |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

    assert_lit_pairing_R5: assert property (@(posedge clk) disable iff (rst)
        lit_valid |-> (issue_valid && issue_op == OP_LIT && fetch_req && word_valid));

    assert_ctrl_ends_word_R6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op[OP_W-1:PAD_W] == '0) |=> !issue_valid);

    assert_redirect_target_R7: assert property (@(posedge clk) disable iff (rst)
        (redirect_req && !stall) |-> !issue_valid);

    assert_redirect_next_R7: assert property (@(posedge clk) disable iff (rst)
        (redirect_req && !stall) |=> (fetch_addr == $past(redirect_target) && !issue_valid));

    assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!issue_valid && !fetch_req && !lit_valid));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_addr) && $stable(issue_slot) && $stable(issue_op)));
endmodule

bind bsq_sequencer bsq_sequencer_chk #(.PC_W(PC_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .stall           (stall),
    .redirect_req    (redirect_req),
    .redirect_target (redirect_target),
    .word_valid      (word_valid),
    .fetch_req       (fetch_req),
    .fetch_addr      (fetch_addr),
    .issue_valid     (issue_valid),
    .issue_op        (issue_op),
    .issue_slot      (issue_slot),
    .lit_valid       (lit_valid)
);

// File: tb/bsq_sequencer_tb.sv
module bsq_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              stall = 1'b0;
    logic              redirect_req = 1'b0;
    logic [PC_W-1:0]   redirect_target = '0;
    logic [17:0]       word_in;
    logic              word_valid;
    logic              fetch_req;
    logic [PC_W-1:0]   fetch_addr;
    logic              issue_valid;
    logic [4:0]        issue_op;
    logic [1:0]        issue_slot;
    logic              lit_valid;
    logic [17:0]       lit_data;

    logic [17:0] mem [64];
    logic        rdy = 1'b1;

    assign word_in    = mem[fetch_addr[5:0]];
    assign word_valid = rdy;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsq_sequencer #(.PC_W(PC_W)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .stall           (stall),
        .redirect_req    (redirect_req),
        .redirect_target (redirect_target),
        .word_in         (word_in),
        .word_valid      (word_valid),
        .fetch_req       (fetch_req),
        .fetch_addr      (fetch_addr),
        .issue_valid     (issue_valid),
        .issue_op        (issue_op),
        .issue_slot      (issue_slot),
        .lit_valid       (lit_valid),
        .lit_data        (lit_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    int ilog_op [64];
    int ilog_slot [64];
    int ilog_cyc [64];
    int ilog_lit [64];
    int ilog_ld [64];
    int n_iss = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && issue_valid && n_iss < 64) begin
            ilog_op[n_iss]   <= int'(issue_op);
            ilog_slot[n_iss] <= int'(issue_slot);
            ilog_cyc[n_iss]  <= cyc;
            ilog_lit[n_iss]  <= int'(lit_valid);
            ilog_ld[n_iss]   <= int'(lit_data);
            n_iss <= n_iss + 1;
        end
    end

    function automatic logic [17:0] pack(int a, int b, int c, int d);
        return {a[4:0], b[4:0], c[4:0], d[2:0]};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = pack(5'h1C, 5'h1C, 5'h1C, 7);
        mem[20] = pack(5'h13, 5'h15, 5'h16, 3);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        stall = 1'b0;
        redirect_req = 1'b0;
        redirect_target = '0;
        rdy = 1'b1;
        step(2);
        n_iss = 0;
        rst = 1'b0;
    endtask

    task automatic t_reset_wait();
        fill_mem();
        mem[0] = pack(5'h10, 5'h11, 5'h12, 5);
        do_reset();
        rdy = 1'b0;
        @(negedge clk);
        chk(fetch_req == 1'b1, "R1", "fetch_req after reset", int'(fetch_req), 1);
        chk(fetch_addr == '0, "R1", "fetch_addr after reset", int'(fetch_addr), 0);
        chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
        repeat (3) begin
            @(negedge clk);
            chk(issue_valid == 1'b0 && fetch_addr == '0, "R9", "waiting fetch",
                int'(issue_valid), 0);
        end
        @(posedge clk);
        #1;
        rdy = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        chk(issue_valid && issue_op == 5'h10 && issue_slot == 0, "R9",
            "first issue after wait", int'(issue_op), 'h10);
    endtask

    task automatic t_plain();
        int exp_op [8] = '{'h10, 'h11, 'h12, 'h14, 'h13, 'h15, 'h16, 'h0C};
        fill_mem();
        mem[0] = pack(5'h10, 5'h11, 5'h12, 5);
        mem[1] = pack(5'h13, 5'h15, 5'h16, 3);
        do_reset();
        step(12);
        chk(n_iss >= 8, "R3", "issue count", n_iss, 8);
        for (int i = 0; i < 8; i++) begin
            chk(ilog_op[i] == exp_op[i], "R2", "slot opcode", ilog_op[i], exp_op[i]);
            chk(ilog_slot[i] == (i % 4), "R2", "slot index", ilog_slot[i], i % 4);
        end
        chk(ilog_cyc[1] - ilog_cyc[0] == 1, "R3", "slot spacing", ilog_cyc[1] - ilog_cyc[0], 1);
        chk(ilog_cyc[4] - ilog_cyc[0] == 5, "R3", "word period", ilog_cyc[4] - ilog_cyc[0], 5);
        chk(fetch_addr == PC_W'(3), "R4", "pc after three fetches", int'(fetch_addr), 3);
    endtask

    task automatic t_literal();
        int exp_op [9] = '{'h10, 'h08, 'h11, 'h1C, 'h12, 'h13, 'h15, 'h08, 'h16};
        int exp_sl [9] = '{0, 1, 2, 3, 0, 1, 2, 3, 0};
        fill_mem();
        mem[0] = pack(5'h10, 5'h08, 5'h11, 7);
        mem[1] = 18'h2ABCD;
        mem[2] = pack(5'h12, 5'h13, 5'h15, 2);
        mem[3] = 18'h01234;
        mem[4] = pack(5'h16, 5'h16, 5'h16, 5);
        do_reset();
        step(14);
        chk(n_iss >= 9, "R5", "issue count", n_iss, 9);
        for (int i = 0; i < 9; i++) begin
            chk(ilog_op[i] == exp_op[i] && ilog_slot[i] == exp_sl[i], "R5",
                "sequence with literals", ilog_op[i], exp_op[i]);
        end
        chk(ilog_lit[1] == 1 && ilog_ld[1] == 'h2ABCD, "R5", "literal data slot 1",
            ilog_ld[1], 'h2ABCD);
        chk(ilog_lit[7] == 1 && ilog_ld[7] == 'h01234, "R5", "literal data slot 3",
            ilog_ld[7], 'h01234);
        chk(ilog_lit[2] == 0, "R5", "no literal flag on plain op", ilog_lit[2], 0);
        chk(ilog_cyc[2] - ilog_cyc[1] == 1, "R3", "literal takes one cycle",
            ilog_cyc[2] - ilog_cyc[1], 1);
        chk(ilog_cyc[8] - ilog_cyc[7] == 2, "R3", "fetch after slot-3 literal",
            ilog_cyc[8] - ilog_cyc[7], 2);
    endtask

    task automatic t_lit_wait();
        fill_mem();
        mem[0] = pack(5'h08, 5'h10, 5'h11, 5);
        mem[1] = 18'h3FFFF;
        do_reset();
        step(1);
        rdy = 1'b0;
        @(negedge clk);
        chk(!issue_valid && fetch_req && fetch_addr == PC_W'(1), "R5",
            "literal waits for data", int'(issue_valid), 0);
        @(posedge clk);
        #1;
        @(negedge clk);
        chk(!issue_valid && !lit_valid, "R5", "literal still waiting", int'(lit_valid), 0);
        @(posedge clk);
        #1;
        rdy = 1'b1;
        @(negedge clk);
        chk(issue_valid && issue_op == 5'h08 && lit_valid && lit_data == 18'h3FFFF,
            "R5", "literal data on arrival", int'(lit_data), 'h3FFFF);
        step(2);
        chk(n_iss >= 2 && ilog_op[1] == 'h10 && ilog_slot[1] == 1, "R5",
            "slot after literal", ilog_op[1], 'h10);
    endtask

    task automatic t_control();
        fill_mem();
        mem[0] = pack(5'h10, 5'h01, 5'h11, 5);
        mem[1] = pack(5'h12, 5'h02, 5'h13, 5);
        do_reset();
        step(8);
        chk(ilog_op[1] == 'h01 && ilog_slot[1] == 1, "R6", "jump issued", ilog_op[1], 'h01);
        chk(ilog_op[2] == 'h12 && ilog_slot[2] == 0, "R6", "slots after jump dropped",
            ilog_op[2], 'h12);
        chk(ilog_cyc[2] - ilog_cyc[1] == 2, "R6", "refetch after jump",
            ilog_cyc[2] - ilog_cyc[1], 2);
        chk(ilog_op[4] == 'h1C && ilog_slot[4] == 0, "R6", "slots after call dropped",
            ilog_op[4], 'h1C);
    endtask

    task automatic t_redirect();
        int guard = 0;
        fill_mem();
        mem[0] = pack(5'h10, 5'h01, 5'h11, 5);
        do_reset();
        do begin
            @(negedge clk);
            guard++;
        end while (!(issue_valid && issue_op == 5'h01) && guard < 20);
        @(posedge clk);
        #1;
        redirect_req = 1'b1;
        redirect_target = PC_W'(20);
        @(negedge clk);
        chk(!issue_valid, "R7", "no issue in redirect cycle", int'(issue_valid), 0);
        @(posedge clk);
        #1;
        redirect_req = 1'b0;
        @(negedge clk);
        chk(fetch_req && fetch_addr == PC_W'(20), "R7", "fetch from target",
            int'(fetch_addr), 20);
        step(3);
        chk(ilog_op[2] == 'h13 && ilog_slot[2] == 0, "R7", "target word issues",
            ilog_op[2], 'h13);
    endtask

    task automatic t_redirect_mid();
        fill_mem();
        mem[0] = pack(5'h10, 5'h11, 5'h12, 5);
        do_reset();
        step(1);
        @(negedge clk);
        chk(issue_valid && issue_op == 5'h10, "R7", "slot 0 before redirect",
            int'(issue_op), 'h10);
        @(posedge clk);
        #1;
        redirect_req = 1'b1;
        redirect_target = PC_W'(20);
        @(negedge clk);
        chk(!issue_valid, "R7", "slot 1 squashed", int'(issue_valid), 0);
        @(posedge clk);
        #1;
        redirect_req = 1'b0;
        step(3);
        chk(ilog_op[1] == 'h13 && ilog_slot[1] == 0, "R7", "next issue from target",
            ilog_op[1], 'h13);
    endtask

    task automatic t_coincide();
        bit any_lit = 0;
        fill_mem();
        mem[0] = pack(5'h08, 5'h10, 5'h11, 5);
        mem[1] = 18'h15555;
        do_reset();
        step(1);
        redirect_req = 1'b1;
        redirect_target = PC_W'(20);
        @(negedge clk);
        chk(!issue_valid && !lit_valid, "R7", "literal cancelled by redirect",
            int'(lit_valid), 0);
        @(posedge clk);
        #1;
        redirect_req = 1'b0;
        step(6);
        for (int i = 0; i < n_iss; i++) if (ilog_lit[i] != 0) any_lit = 1;
        chk(!any_lit, "R5", "literal word not consumed", int'(any_lit), 0);
        chk(n_iss > 0 && ilog_op[0] == 'h13 && ilog_slot[0] == 0, "R7",
            "target after cancelled literal", ilog_op[0], 'h13);
    endtask

    task automatic t_stall();
        fill_mem();
        mem[0] = pack(5'h10, 5'h11, 5'h12, 5);
        do_reset();
        step(2);
        stall = 1'b1;
        redirect_req = 1'b1;
        redirect_target = PC_W'(20);
        @(negedge clk);
        chk(!issue_valid && !fetch_req, "R8", "quiet while stalled", int'(issue_valid), 0);
        chk(issue_op == 5'h11 && issue_slot == 2'd1, "R8", "held opcode",
            int'(issue_op), 'h11);
        @(posedge clk);
        #1;
        redirect_req = 1'b0;
        @(negedge clk);
        chk(issue_op == 5'h11 && issue_slot == 2'd1 && fetch_addr == PC_W'(1), "R8",
            "state held second cycle", int'(issue_slot), 1);
        @(posedge clk);
        #1;
        stall = 1'b0;
        step(5);
        chk(ilog_op[1] == 'h11 && ilog_slot[1] == 1, "R10", "resume at held slot",
            ilog_op[1], 'h11);
        chk(ilog_cyc[1] - ilog_cyc[0] == 3, "R8", "stall delay", ilog_cyc[1] - ilog_cyc[0], 3);
        chk(ilog_op[4] == 'h1C && ilog_slot[4] == 0, "R10", "redirect under stall ignored",
            ilog_op[4], 'h1C);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        fill_mem();
        t_reset_wait();
        t_plain();
        t_literal();
        t_lit_wait();
        t_control();
        t_redirect();
        t_redirect_mid();
        t_coincide();
        t_stall();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule